// File: doc/BRIEF.md
# CAN Fault Confinement Counters

This block holds the transmit error counter and the receive error counter of a CAN controller. From these counters it derives the node's fault state: error-active, error-passive or bus-off. The error sequencer drives it with single-cycle event pulses. The pulses mark error frames sent as transmitter, receive errors, ACK errors, dominant bits sampled during a passive error flag, the end of a passive error flag, successful transmissions and receptions, protocol exceptions and device start commands.

Error-passive transmitters get special handling for ACK errors. When such a transmitter sees an ACK error, the block does not raise the transmit counter at once. It arms a pending flag and waits to see whether a dominant bit appears during the passive error flag that follows.

A protocol exception sends the node to integration and does not touch the counters. The counters return to zero only when the device is started while it is bus-off. The counters and the state are registered, and they update on the clock edge that samples the event.

Top module: `can_fault_confine`

## Requirements
- R1: A transmitter error frame pulse (`tx_err_i`) adds 8 to TEC. It takes priority over a simultaneous ACK-error, dominant-flag or success pulse on TEC.
- R2: An ACK error (`ack_err_i`) in the error-active state adds 8 to TEC. In the error-passive state it leaves TEC unchanged and arms a pending flag.
- R3: While the pending flag is armed, a dominant-during-passive-flag pulse (`flag_dom_i`) adds 8 to TEC once and disarms the flag. The flag is also disarmed by `flag_done_i`, `tx_err_i`, `tx_ok_i` or `proto_exc_i`.
- R4: A `flag_dom_i` pulse while the pending flag is not armed changes neither counter.
- R5: `tx_ok_i` subtracts 1 from TEC and `rx_ok_i` subtracts 1 from REC. Neither counter goes below 0.
- R6: `rx_err_i` adds 1 to REC and holds REC at 511 (all ones, 9 bits) instead of wrapping. A simultaneous `rx_ok_i` is then ignored.
- R7: `proto_exc_i` leaves TEC and REC unchanged.
- R8: `start_i` in the bus-off state clears TEC, REC and the pending flag, and the state returns to active. `start_i` in any other state changes neither counter.
- R9: `state_o` encodes 0 for error-active, 1 for error-passive and 2 for bus-off. It is 2 when TEC > 255, otherwise 1 when TEC > 127 or REC > 127, otherwise 0. It changes on the same edge as the counters.
- R10: In the bus-off state, every event other than `start_i` leaves both counters unchanged.
- R11: After reset, TEC = 0, REC = 0 and the state is error-active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_err_i | input | 1 | Error frame sent while transmitter |
| ack_err_i | input | 1 | ACK error detected as transmitter |
| flag_dom_i | input | 1 | Dominant bit sampled during a passive error flag |
| flag_done_i | input | 1 | Passive error flag completed |
| rx_err_i | input | 1 | Error detected as receiver |
| tx_ok_i | input | 1 | Frame transmitted successfully |
| rx_ok_i | input | 1 | Frame received successfully |
| proto_exc_i | input | 1 | Protocol exception, node enters integration |
| start_i | input | 1 | Device start command |
| tec_o | output | 9 | Transmit error counter |
| rec_o | output | 9 | Receive error counter |
| state_o | output | 2 | Fault state (0 active, 1 passive, 2 bus-off) |

## Verification
A wrong counter value shows at `tec_o` or `rec_o` on the first edge after the event that caused it. It also shifts the passive and bus-off thresholds, so `state_o` flips at the wrong event count. A pending ACK flag that is stuck armed or stuck clear cannot be seen until a later dominant-flag pulse arrives. The bench therefore follows each ACK error with both kinds of flag outcome and compares TEC on the edge after that pulse.

// File: rtl/can_fc_pkg.sv
package can_fc_pkg;
  typedef enum logic [1:0] {
    FC_ACTIVE  = 2'd0,
    FC_PASSIVE = 2'd1,
    FC_BUSOFF  = 2'd2
  } fc_state_e;
endpackage

// File: rtl/fc_tec_unit.sv
module fc_tec_unit #(
  parameter int CNT_W    = 9,
  parameter int INC_STEP = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tx_err,
  input  logic             ack_err,
  input  logic             flag_dom,
  input  logic             flag_done,
  input  logic             proto_exc,
  input  logic             tx_ok,
  input  logic             start,
  input  logic             is_passive,
  input  logic             is_busoff,
  output logic [CNT_W-1:0] tec_q,
  output logic [CNT_W-1:0] tec_d
);
  localparam logic [CNT_W:0]   CNT_MAX = {1'b0, {CNT_W{1'b1}}};
  localparam logic [CNT_W:0]   STEP    = (CNT_W+1)'(INC_STEP);

  logic             pend_q, pend_d;
  logic [CNT_W:0]   sum_w;
  logic [CNT_W-1:0] add_sat;

  // widened add, clamp to the counter maximum
  assign sum_w   = {1'b0, tec_q} + STEP;
  assign add_sat = (sum_w > CNT_MAX) ? CNT_MAX[CNT_W-1:0] : sum_w[CNT_W-1:0];

  always_comb begin
    tec_d  = tec_q;
    pend_d = pend_q;
    if (start) begin
      if (is_busoff) begin
        tec_d  = '0;
        pend_d = 1'b0;
      end
    end else if (!is_busoff) begin
      if (tx_err || (ack_err && !is_passive))
        tec_d = add_sat;
      else if (flag_dom && pend_q)
        tec_d = add_sat;
      else if (tx_ok && (tec_q != '0))
        tec_d = tec_q - 1'b1;

      if (ack_err && is_passive && !tx_err)
        pend_d = 1'b1;
      else if (flag_dom || flag_done || proto_exc || tx_ok || tx_err)
        pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tec_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      tec_q  <= tec_d;
      pend_q <= pend_d;
    end
  end
endmodule

// File: rtl/fc_rec_unit.sv
module fc_rec_unit #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_err,
  input  logic             rx_ok,
  input  logic             start,
  input  logic             is_busoff,
  output logic [CNT_W-1:0] rec_q,
  output logic [CNT_W-1:0] rec_d
);
  localparam logic [CNT_W-1:0] REC_MAX = {CNT_W{1'b1}};

  always_comb begin
    rec_d = rec_q;
    if (start) begin
      if (is_busoff) rec_d = '0;
    end else if (!is_busoff) begin
      if (rx_err) begin
        if (rec_q != REC_MAX) rec_d = rec_q + 1'b1;
      end else if (rx_ok && (rec_q != '0)) begin
        rec_d = rec_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rec_q <= '0;
    else     rec_q <= rec_d;
  end
endmodule

// File: rtl/fc_state_dec.sv
module fc_state_dec
  import can_fc_pkg::*;
#(
  parameter int CNT_W       = 9,
  parameter int PASSIVE_LIM = 127,
  parameter int BUSOFF_LIM  = 255
) (
  input  logic [CNT_W-1:0] tec,
  input  logic [CNT_W-1:0] rec,
  output fc_state_e        state
);
  localparam logic [CNT_W-1:0] P_LIM = CNT_W'(PASSIVE_LIM);
  localparam logic [CNT_W-1:0] B_LIM = CNT_W'(BUSOFF_LIM);

  always_comb begin
    if (tec > B_LIM)                       state = FC_BUSOFF;
    else if ((tec > P_LIM) || (rec > P_LIM)) state = FC_PASSIVE;
    else                                   state = FC_ACTIVE;
  end
endmodule

// File: rtl/can_fault_confine.sv
module can_fault_confine
  import can_fc_pkg::*;
#(
  parameter int CNT_W       = 9,
  parameter int INC_STEP    = 8,
  parameter int PASSIVE_LIM = 127,
  parameter int BUSOFF_LIM  = 255
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tx_err_i,
  input  logic             ack_err_i,
  input  logic             flag_dom_i,
  input  logic             flag_done_i,
  input  logic             rx_err_i,
  input  logic             tx_ok_i,
  input  logic             rx_ok_i,
  input  logic             proto_exc_i,
  input  logic             start_i,
  output logic [CNT_W-1:0] tec_o,
  output logic [CNT_W-1:0] rec_o,
  output logic [1:0]       state_o
);
  fc_state_e        state_q, state_d;
  logic [CNT_W-1:0] tec_d, rec_d;
  logic             passive_w, busoff_w;

  assign passive_w = (state_q == FC_PASSIVE);
  assign busoff_w  = (state_q == FC_BUSOFF);

  fc_tec_unit #(.CNT_W(CNT_W), .INC_STEP(INC_STEP)) u_tec (
    .clk        (clk),
    .rst        (rst),
    .tx_err     (tx_err_i),
    .ack_err    (ack_err_i),
    .flag_dom   (flag_dom_i),
    .flag_done  (flag_done_i),
    .proto_exc  (proto_exc_i),
    .tx_ok      (tx_ok_i),
    .start      (start_i),
    .is_passive (passive_w),
    .is_busoff  (busoff_w),
    .tec_q      (tec_o),
    .tec_d      (tec_d)
  );

  fc_rec_unit #(.CNT_W(CNT_W)) u_rec (
    .clk       (clk),
    .rst       (rst),
    .rx_err    (rx_err_i),
    .rx_ok     (rx_ok_i),
    .start     (start_i),
    .is_busoff (busoff_w),
    .rec_q     (rec_o),
    .rec_d     (rec_d)
  );

  // state is decoded from next-cycle counters so it moves with them
  fc_state_dec #(
    .CNT_W(CNT_W), .PASSIVE_LIM(PASSIVE_LIM), .BUSOFF_LIM(BUSOFF_LIM)
  ) u_dec (
    .tec   (tec_d),
    .rec   (rec_d),
    .state (state_d)
  );

  always_ff @(posedge clk) begin
    if (rst) state_q <= FC_ACTIVE;
    else     state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/fc_checker.sv
module fc_checker #(
  parameter int CNT_W       = 9,
  parameter int INC_STEP    = 8,
  parameter int PASSIVE_LIM = 127,
  parameter int BUSOFF_LIM  = 255
) (
  input logic             clk,
  input logic             rst,
  input logic             tx_err_i,
  input logic             ack_err_i,
  input logic             flag_dom_i,
  input logic             flag_done_i,
  input logic             rx_err_i,
  input logic             tx_ok_i,
  input logic             rx_ok_i,
  input logic             proto_exc_i,
  input logic             start_i,
  input logic [CNT_W-1:0] tec_o,
  input logic [CNT_W-1:0] rec_o,
  input logic [1:0]       state_o
);
  logic busoff_c, passive_c, others_idle;
  assign busoff_c    = (state_o == 2'd2);
  assign passive_c   = (state_o == 2'd1);
  assign others_idle = !(tx_err_i | ack_err_i | flag_dom_i | rx_err_i |
                         tx_ok_i | rx_ok_i | start_i);

  // R1
  p_txerr_step_r1: assert property (@(posedge clk) disable iff (rst)
    (tx_err_i && !start_i && !busoff_c) |=>
      (32'(tec_o) == 32'($past(tec_o)) + INC_STEP));

  // R2
  p_ack_passive_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (ack_err_i && !tx_err_i && !start_i && passive_c && !flag_dom_i) |=>
      (tec_o == $past(tec_o)));

  // R5
  p_txok_floor_r5: assert property (@(posedge clk) disable iff (rst)
    (tx_ok_i && !tx_err_i && !ack_err_i && !flag_dom_i && !start_i &&
     tec_o == '0) |=> (tec_o == '0));

  // R6
  p_rec_no_wrap_r6: assert property (@(posedge clk) disable iff (rst)
    (rx_err_i && !start_i && !busoff_c) |=>
      (rec_o >= $past(rec_o)) && (rec_o != '0));

  // R7
  p_proto_keep_r7: assert property (@(posedge clk) disable iff (rst)
    (proto_exc_i && others_idle) |=> ($stable(tec_o) && $stable(rec_o)));

  // R8
  p_busoff_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (start_i && busoff_c) |=> (tec_o == '0 && rec_o == '0 && state_o == 2'd0));

  // R9
  p_state_map_r9: assert property (@(posedge clk) disable iff (rst)
    (busoff_c == (32'(tec_o) > BUSOFF_LIM)) &&
    (passive_c == (!busoff_c &&
      ((32'(tec_o) > PASSIVE_LIM) || (32'(rec_o) > PASSIVE_LIM)))));

  // R10
  p_busoff_frozen_r10: assert property (@(posedge clk) disable iff (rst)
    (busoff_c && !start_i) |=> ($stable(tec_o) && $stable(rec_o)));
endmodule

bind can_fault_confine fc_checker #(
  .CNT_W(CNT_W), .INC_STEP(INC_STEP),
  .PASSIVE_LIM(PASSIVE_LIM), .BUSOFF_LIM(BUSOFF_LIM)
) u_fc_checker (
  .clk(clk), .rst(rst), .tx_err_i(tx_err_i), .ack_err_i(ack_err_i),
  .flag_dom_i(flag_dom_i), .flag_done_i(flag_done_i), .rx_err_i(rx_err_i),
  .tx_ok_i(tx_ok_i), .rx_ok_i(rx_ok_i), .proto_exc_i(proto_exc_i),
  .start_i(start_i), .tec_o(tec_o), .rec_o(rec_o), .state_o(state_o)
);

// File: tb/test_can_fault_confine.sv
`timescale 1ns/1ps
module test_can_fault_confine;
  localparam int W = 9;
  // event bit positions in the driver vector
  localparam int E_TXERR = 0, E_ACK = 1, E_DOM = 2, E_DONE = 3, E_RXERR = 4,
                 E_TXOK = 5, E_RXOK = 6, E_PEXC = 7, E_START = 8;

  typedef struct {
    int    tec;
    int    rec;
    int    st;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [8:0] ev = '0;
  logic [W-1:0] tec_o, rec_o;
  logic [1:0]   state_o;

  exp_t q[$];
  int applied = 0;
  int miscomp = 0;
  int m_tec = 0, m_rec = 0;
  bit m_pend = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  can_fault_confine i_can_fault_confine (
    .clk(clk), .rst(rst),
    .tx_err_i(ev[E_TXERR]), .ack_err_i(ev[E_ACK]), .flag_dom_i(ev[E_DOM]),
    .flag_done_i(ev[E_DONE]), .rx_err_i(ev[E_RXERR]), .tx_ok_i(ev[E_TXOK]),
    .rx_ok_i(ev[E_RXOK]), .proto_exc_i(ev[E_PEXC]), .start_i(ev[E_START]),
    .tec_o(tec_o), .rec_o(rec_o), .state_o(state_o)
  );

  function automatic int m_state(int t, int r);
    if (t > 255) return 2;
    if (t > 127 || r > 127) return 1;
    return 0;
  endfunction

  // driver: compute the expected result from the requirements, then drive
  task automatic apply(input logic [8:0] e, input string tag);
    int  st;
    bit  bo, pas;
    @(negedge clk);
    st  = m_state(m_tec, m_rec);
    bo  = (st == 2);
    pas = (st == 1);
    if (e[E_START]) begin
      if (bo) begin m_tec = 0; m_rec = 0; m_pend = 1'b0; end
    end else if (!bo) begin
      if (e[E_TXERR] || (e[E_ACK] && !pas)) m_tec = m_tec + 8;
      else if (e[E_DOM] && m_pend)          m_tec = m_tec + 8;
      else if (e[E_TXOK] && m_tec > 0)      m_tec = m_tec - 1;
      if (e[E_ACK] && pas && !e[E_TXERR]) m_pend = 1'b1;
      else if (e[E_DOM] || e[E_DONE] || e[E_PEXC] || e[E_TXOK] || e[E_TXERR])
        m_pend = 1'b0;
      if (e[E_RXERR]) begin
        if (m_rec < 511) m_rec = m_rec + 1;
      end else if (e[E_RXOK] && m_rec > 0) m_rec = m_rec - 1;
    end
    ev = e;
    q.push_back('{m_tec, m_rec, m_state(m_tec, m_rec), tag});
  endtask

  task automatic repeat_ev(input logic [8:0] e, input int n, input string tag);
    for (int i = 0; i < n; i++) apply(e, tag);
  endtask

  // monitor: compare one expected item per clock, away from the edge
  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      exp_t x;
      x = q.pop_front();
      applied++;
      if (int'(tec_o) != x.tec || int'(rec_o) != x.rec || int'(state_o) != x.st) begin
        miscomp++;
        $display("FAIL %s: tec=%0d rec=%0d st=%0d expected tec=%0d rec=%0d st=%0d",
                 x.tag, tec_o, rec_o, state_o, x.tec, x.rec, x.st);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    apply('0, "R11 reset state");
    apply(9'(1 << E_TXERR), "R1 tx error adds 8");
    apply(9'(1 << E_TXOK), "R5 tx ok subtracts 1");
    repeat_ev(9'(1 << E_TXOK), 8, "R5 tx ok floor at 0");
    apply(9'(1 << E_RXERR), "R6 rx error adds 1");
    repeat_ev(9'(1 << E_RXOK), 2, "R5 rx ok floor at 0");
    apply(9'((1 << E_TXERR) | (1 << E_TXOK)), "R1 priority over tx ok");
    repeat_ev(9'(1 << E_TXOK), 8, "R5 drain");
    apply(9'(1 << E_ACK), "R2 ack error while active adds 8");
    repeat_ev(9'(1 << E_TXOK), 8, "R5 drain");
    apply(9'(1 << E_DOM), "R4 dominant flag without pending");
    repeat_ev(9'(1 << E_RXERR), 127, "R9 rec up to 127 stays active");
    apply(9'(1 << E_RXERR), "R9 rec 128 passive");
    apply(9'(1 << E_ACK), "R2 ack error while passive holds tec");
    apply(9'(1 << E_DONE), "R3 flag done disarms");
    apply(9'(1 << E_DOM), "R4 dominant after disarm no change");
    apply(9'(1 << E_ACK), "R2 ack error while passive holds tec");
    apply(9'(1 << E_DOM), "R3 dominant after passive ack adds 8");
    apply(9'(1 << E_DOM), "R3 only once");
    apply(9'(1 << E_ACK), "R2 arm again");
    apply(9'(1 << E_PEXC), "R7 proto exception keeps counters");
    apply(9'(1 << E_DOM), "R3 proto exception disarmed");
    apply(9'(1 << E_START), "R8 start while passive no change");
    repeat_ev(9'(1 << E_RXERR), 383, "R6 rec climbs");
    repeat_ev(9'(1 << E_RXERR), 2, "R6 rec saturates at 511");
    apply(9'((1 << E_RXERR) | (1 << E_RXOK)), "R6 saturated with rx ok");
    repeat_ev(9'(1 << E_TXERR), 30, "R1 tec climbs");
    apply(9'(1 << E_TXERR), "R9 tec 256 bus-off");
    apply(9'(1 << E_RXOK), "R10 rx ok frozen in bus-off");
    apply(9'(1 << E_TXOK), "R10 tx ok frozen in bus-off");
    apply(9'(1 << E_TXERR), "R10 tx error frozen in bus-off");
    apply(9'(1 << E_PEXC), "R7 proto exception in bus-off");
    apply(9'(1 << E_START), "R8 start from bus-off clears");
    apply('0, "R8 idle after restart");
    @(negedge clk);
    ev = '0;
    repeat (3) @(negedge clk);
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 100000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      miscomp++;
      $display("FAIL watchdog: run did not complete, expected completion");
    end
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscomp);
    $finish;
  end
endmodule